// File: doc/BRIEF.md
# Transmit Holding-Register-Empty Interrupt Logic

This block raises the "transmit holding register empty" indication and the matching interrupt request for a UART whose transmit FIFO holds up to sixteen characters. It watches the FIFO occupancy, CPU writes to the holding register and CPU reads of the interrupt identification register. From these it produces the THRE status bit, a transmit interrupt request and the identification code for that request. The serializer and the FIFO storage sit outside the block.

When the FIFO drains after holding only one character at a time, the empty indication is held back for one character time less the final stop bit, counted in baud ticks. This gives the transmitter a chance to finish a lone character before software is asked to refill. When the FIFO held at least two characters at once since the previous empty event, the indication appears on the next clock edge. A change of the FIFO-enable bit raises the interrupt at once. Clearing the interrupt enable gives polled operation: the status bit still tracks the FIFO, but no request is driven.

The core is a three-state machine. EMPTY means THRE = 1. LOADED means the FIFO holds data. DELAY means the FIFO is empty and the hold-off timer is running. The transitions are:
- EMPTY→LOADED: on a write or a nonzero count.
- LOADED→EMPTY: on a zero count after a burst.
- LOADED→DELAY: on a zero count with no burst; this loads the timer.
- DELAY→LOADED: on a write or a nonzero count, which cancels the timer.
- DELAY→EMPTY: when the timer expires or the FIFO-enable bit changes.

Every entry into EMPTY from another state is a THRE event.

Top module: `txe_thre_irq`

## Requirements
- R1: After reset, thre = 1, tx_irq = 0 and tx_iid = 4'h1. No interrupt is pending.
- R2: While THRE is 1, a cycle with thr_wr = 1 or a nonzero tx_count makes thre 0 from the next clock edge.
- R3: If tx_count reached 2 or more at any time since the last THRE event, then the edge after tx_count returns to 0 sets thre = 1 and sets the pending interrupt.
- R4: Otherwise, thre stays 0 until D baud_en pulses have been sampled after the FIFO emptied, and turns 1 on the D-th pulse. D = 1 + (5 + word_len) + parity_en + two_stop, where word_len 2'b00..2'b11 selects 5..8 data bits.
- R5: A write or a nonzero tx_count during the hold-off cancels it. The next time the FIFO empties, a full D-pulse hold-off starts again.
- R6: Each THRE event sets the pending interrupt. With tx_ie = 1, tx_irq rises together with thre. tx_iid = 4'h2 while tx_irq = 1 and hi_pend = 0.
- R7: A holding-register write clears the pending interrupt on the next edge.
- R8: An iir_rd while tx_iid = 4'h2 clears the pending interrupt. An iir_rd while tx_iid is not 4'h2 leaves it pending.
- R9: A change of fifo_en sets the pending interrupt on the next edge. If the hold-off is running, the change also ends it with thre = 1.
- R10: With tx_ie = 0 (polled), tx_irq = 0 and tx_iid = 4'h1 while thre keeps tracking the FIFO. A pending interrupt appears on tx_irq once tx_ie returns to 1.
- R11: While hi_pend = 1 (a line status, data available or timeout source is active), tx_iid is 4'h1 and tx_irq is unaffected.
- R12: The burst record is cleared at every THRE event. A following single-character drain is therefore delayed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_count | input | 5 | Current transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | CPU write strobe to the holding register |
| iir_rd | input | 1 | CPU read strobe of the interrupt identification register |
| tx_ie | input | 1 | Transmit interrupt enable |
| fifo_en | input | 1 | FIFO-enable control bit |
| baud_en | input | 1 | One pulse per serial bit time |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Two stop bits in the frame |
| hi_pend | input | 1 | A higher-priority interrupt source is active |
| thre | output | 1 | Holding register empty status |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_iid | output | 4 | 4'h2 when this source is reported, 4'h1 otherwise |

## Verification
The bench counts baud pulses across the hold-off for two frame formats and samples thre both one pulse early and on the last pulse. An off-by-one timer load, or a delay that counts the dropped stop bit, shows up at one of these two points. A cancelled hold-off is resumed later, so a design that keeps the stale count instead of reloading would raise THRE too early. The burst path is followed by a single-character drain, which catches a burst flag that is never cleared: such a design would skip the delay. Reads of the identification register while a higher source is active, and a fifo_en toggle mid-delay, check that the interrupt is neither lost nor late.

// File: rtl/txe_pkg.sv
package txe_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_LOADED = 2'd1,
        ST_DELAY  = 2'd2
    } txe_state_t;

    localparam logic [3:0] IID_TX   = 4'h2;
    localparam logic [3:0] IID_NONE = 4'h1;

    // start bit + data bits + parity + stop bits other than the last one
    function automatic logic [3:0] hold_ticks(input logic [1:0] wl,
                                              input logic       par,
                                              input logic       stop2);
        return 4'd6 + {2'b00, wl} + {3'b000, par} + {3'b000, stop2};
    endfunction

endpackage

// File: rtl/txe_delay_timer.sv
module txe_delay_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = tick && !load && (cnt == W'(1));
endmodule

// File: rtl/txe_burst_flag.sv
module txe_burst_flag #(
    parameter int CW          = 5,
    parameter int BURST_LEVEL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          clear,
    output logic          seen
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else if (clear)
            seen <= 1'b0;
        else if (count >= CW'(BURST_LEVEL))
            seen <= 1'b1;
    end
endmodule

// File: rtl/txe_fcr_edge.sv
module txe_fcr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic changed
);
    logic level_q;
    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            primed  <= 1'b0;
        end else begin
            level_q <= level;
            primed  <= 1'b1;
        end
    end

    assign changed = primed && (level != level_q);
endmodule

// File: rtl/txe_thre_irq.sv
module txe_thre_irq
    import txe_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int BURST_LEVEL = 2,
    parameter int CW          = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic          thr_wr,
    input  logic          iir_rd,
    input  logic          tx_ie,
    input  logic          fifo_en,
    input  logic          baud_en,
    input  logic [1:0]    word_len,
    input  logic          parity_en,
    input  logic          two_stop,
    input  logic          hi_pend,
    output logic          thre,
    output logic          tx_irq,
    output logic [3:0]    tx_iid
);
    localparam int TW = 4;

    txe_state_t state, state_nx;
    logic       loaded_now;
    logic       thre_event;
    logic       tmr_load;
    logic       tmr_expire;
    logic       burst_seen;
    logic       fe_chg;
    logic       pend;

    assign loaded_now = thr_wr || (tx_count != '0);

    txe_delay_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (hold_ticks(word_len, parity_en, two_stop)),
        .tick     (baud_en),
        .expire   (tmr_expire)
    );

    txe_burst_flag #(.CW(CW), .BURST_LEVEL(BURST_LEVEL)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tx_count),
        .clear (thre_event),
        .seen  (burst_seen)
    );

    txe_fcr_edge u_fcr (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (fifo_en),
        .changed (fe_chg)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (loaded_now)
                    state_nx = ST_LOADED;
            end
            ST_LOADED: begin
                if (!loaded_now) begin
                    if (burst_seen) begin
                        state_nx = ST_EMPTY;
                    end else begin
                        state_nx = ST_DELAY;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (loaded_now)
                    state_nx = ST_LOADED;
                else if (fe_chg || tmr_expire)
                    state_nx = ST_EMPTY;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    assign thre_event = (state != ST_EMPTY) && (state_nx == ST_EMPTY);

    // pending interrupt latch: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (thre_event || fe_chg)
            pend <= 1'b1;
        else if (thr_wr || (iir_rd && tx_iid == IID_TX))
            pend <= 1'b0;
    end

    // outputs
    always_comb begin
        thre   = (state == ST_EMPTY);
        tx_irq = pend && tx_ie;
        tx_iid = (tx_irq && !hi_pend) ? IID_TX : IID_NONE;
    end
endmodule

// File: rtl/txe_thre_irq_chk.sv
module txe_thre_irq_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] tx_count,
    input logic          thr_wr,
    input logic          tx_ie,
    input logic          fifo_en,
    input logic          hi_pend,
    input logic          thre,
    input logic          tx_irq,
    input logic [3:0]    tx_iid
);
    logic fe_q, fe_primed, fe_moved;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q      <= 1'b0;
            fe_primed <= 1'b0;
        end else begin
            fe_q      <= fifo_en;
            fe_primed <= 1'b1;
        end
    end

    assign fe_moved = fe_primed && (fifo_en != fe_q);

    a_r2_load_drops_thre: assert property (@(posedge clk) disable iff (!rst_n)
        thre && (thr_wr || tx_count != '0) |=> !thre);

    a_r6_irq_with_thre: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thre) && tx_ie |-> tx_irq);

    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr && tx_count != '0 && !fe_moved |=> !tx_irq);

    a_r10_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ie |-> !tx_irq && tx_iid == 4'h1);

    a_r11_priority: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pend |-> tx_iid != 4'h2);
endmodule

bind txe_thre_irq txe_thre_irq_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_count (tx_count),
    .thr_wr   (thr_wr),
    .tx_ie    (tx_ie),
    .fifo_en  (fifo_en),
    .hi_pend  (hi_pend),
    .thre     (thre),
    .tx_irq   (tx_irq),
    .tx_iid   (tx_iid)
);

// File: tb/txe_thre_irq_tb.sv
`timescale 1ns/1ps
module txe_thre_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] tx_count;
    logic       thr_wr, iir_rd, tx_ie, fifo_en, baud_en;
    logic [1:0] word_len;
    logic       parity_en, two_stop, hi_pend;
    logic       thre, tx_irq;
    logic [3:0] tx_iid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    txe_thre_irq u_dut (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .thr_wr(thr_wr),
        .iir_rd(iir_rd), .tx_ie(tx_ie), .fifo_en(fifo_en), .baud_en(baud_en),
        .word_len(word_len), .parity_en(parity_en), .two_stop(two_stop),
        .hi_pend(hi_pend), .thre(thre), .tx_irq(tx_irq), .tx_iid(tx_iid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic baud(input int n);
        for (int i = 0; i < n; i++) begin
            baud_en = 1'b1; step();
            baud_en = 1'b0; step();
        end
    endtask

    task automatic t_reset();
        chk("R1 thre", thre, 1);
        chk("R1 irq", tx_irq, 0);
        chk("R1 iid", tx_iid, 4'h1);
    endtask

    task automatic t_single_delay();
        thr_wr = 1'b1; tx_count = 5'd1; step();
        chk("R2 thre low after write", thre, 0);
        thr_wr = 1'b0; step();
        tx_count = 5'd0; step();
        chk("R4 held off", thre, 0);
        baud(8);
        chk("R4 thre before 9th tick", thre, 0);
        baud(1);
        chk("R4 thre on 9th tick", thre, 1);
        chk("R6 irq", tx_irq, 1);
        chk("R6 iid", tx_iid, 4'h2);
    endtask

    task automatic t_write_and_burst();
        thr_wr = 1'b1; tx_count = 5'd2; step();
        chk("R7 write clears irq", tx_irq, 0);
        thr_wr = 1'b0; step();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        chk("R3 burst thre", thre, 1);
        chk("R3 burst irq", tx_irq, 1);
    endtask

    task automatic t_iir_clear();
        iir_rd = 1'b1; step();
        iir_rd = 1'b0;
        chk("R8 iir read clears", tx_irq, 0);
        chk("R8 thre kept", thre, 1);
    endtask

    task automatic t_sticky_cleared();
        word_len = 2'b00; parity_en = 1'b1; two_stop = 1'b1;
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        step();
        chk("R12 delay again after burst", thre, 0);
        baud(7);
        chk("R4 fmt2 before 8th tick", thre, 0);
        baud(1);
        chk("R4 fmt2 on 8th tick", thre, 1);
    endtask

    task automatic t_cancel();
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        baud(3);
        tx_count = 5'd1; step();
        chk("R5 cancelled thre", thre, 0);
        baud(6);
        tx_count = 5'd0; step();
        baud(7);
        chk("R5 full restart", thre, 0);
        baud(1);
        chk("R5 thre after restart", thre, 1);
    endtask

    task automatic t_priority();
        hi_pend = 1'b1; step();
        chk("R11 iid masked", tx_iid, 4'h1);
        chk("R11 irq kept", tx_irq, 1);
        iir_rd = 1'b1; step();
        iir_rd = 1'b0; hi_pend = 1'b0; step();
        chk("R8 read while masked ignored", tx_iid, 4'h2);
    endtask

    task automatic t_fifo_toggle();
        iir_rd = 1'b1; step();
        iir_rd = 1'b0;
        chk("R8 clear before toggle", tx_irq, 0);
        tx_count = 5'd1; step();
        tx_count = 5'd0; step();
        baud(2);
        fifo_en = 1'b0; step();
        chk("R9 toggle ends delay", thre, 1);
        chk("R9 toggle irq", tx_irq, 1);
    endtask

    task automatic t_polled();
        tx_ie = 1'b0; step();
        chk("R10 irq off", tx_irq, 0);
        chk("R10 iid none", tx_iid, 4'h1);
        tx_count = 5'd1; step();
        chk("R10 thre tracks load", thre, 0);
        tx_count = 5'd0; step();
        baud(8);
        chk("R10 thre tracks empty", thre, 1);
        chk("R10 still no irq", tx_irq, 0);
        tx_ie = 1'b1; step();
        chk("R10 latched irq shows", tx_irq, 1);
    endtask

    initial begin
        rst_n = 1'b0; tx_count = '0; thr_wr = 0; iir_rd = 0; tx_ie = 1;
        fifo_en = 1; baud_en = 0; word_len = 2'b11; parity_en = 0;
        two_stop = 0; hi_pend = 0;
        repeat (3) step();
        rst_n = 1'b1; step();
        t_reset();
        t_single_delay();
        t_write_and_burst();
        t_iir_clear();
        t_sticky_cleared();
        t_cancel();
        t_priority();
        t_fifo_toggle();
        t_polled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule